// File: doc/BRIEF.md
# Keyboard/Auxiliary Output Buffer Arbiter

This block merges the "byte waiting" levels of two input sources, a keyboard channel and an auxiliary (pointing device) channel, into the flags a host reads from a keyboard controller. It produces the output-buffer-full flags, their copies on the controller's output port, one interrupt request level per source, and the choice of which source supplies the next byte read from the data port. The source queues and the host bus are outside the block. The block only follows input levels.

The keyboard channel has fixed priority. The auxiliary channel is presented only when it is the only channel holding data. The keyboard interrupt can be masked in two ways: by its own enable bit, or by the bit that turns the keyboard interface off. The auxiliary interrupt has only its enable bit.

Every output is registered. A change on any input is visible one clock later.

Top module: `kbd_obuf_arbiter`

## Requirements
- R1: While `rstN` is low, all outputs read 0: flags, port copies, interrupts, `readSelAux` and `readByte`.
- R2: One clock after the inputs are sampled, `statusObf` equals `kbdPending OR auxPending`.
- R3: One clock after sampling, `statusAuxObf` is 1 only when `auxPending` is 1 and `kbdPending` is 0. When both channels are pending, the keyboard channel wins.
- R4: One clock after sampling, `irqAux` is 1 only when the auxiliary channel is the sole pending one and `modeAuxIrqEn` is 1.
- R5: One clock after sampling, `irqKbd` is 1 only when `kbdPending` is 1, `modeKbdIrqEn` is 1 and `modeKbdOff` is 0.
- R6: `portObf` always equals `statusObf`, and `portAuxObf` always equals `statusAuxObf`.
- R7: One clock after sampling, `readSelAux` equals the auxiliary-only condition. `readByte` equals `auxByte` in that case and `kbdByte` in every other case, including when nothing is pending.
- R8: When neither channel is pending, one clock later both flags, both port copies and both interrupt lines are 0, whatever the mode bits are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| kbdPending | input | 1 | Keyboard channel holds a byte |
| auxPending | input | 1 | Auxiliary channel holds a byte |
| modeKbdIrqEn | input | 1 | Keyboard interrupt enable |
| modeAuxIrqEn | input | 1 | Auxiliary interrupt enable |
| modeKbdOff | input | 1 | Keyboard interface switched off; masks the keyboard interrupt |
| kbdByte | input | DATA_W | Head byte of the keyboard channel |
| auxByte | input | DATA_W | Head byte of the auxiliary channel |
| statusObf | output | 1 | Output buffer full flag |
| statusAuxObf | output | 1 | Auxiliary output buffer full flag |
| portObf | output | 1 | Output port copy of `statusObf` |
| portAuxObf | output | 1 | Output port copy of `statusAuxObf` |
| irqKbd | output | 1 | Keyboard interrupt request level |
| irqAux | output | 1 | Auxiliary interrupt request level |
| readSelAux | output | 1 | 1 when the data port reads from the auxiliary channel |
| readByte | output | DATA_W | Byte presented to the data port |

## Verification
Every result, flags, port copies, interrupts, select and data byte, is due exactly one rising edge after its inputs are applied.

The bench drives inputs on the falling edge. It compares all outputs at the next falling edge, after exactly one rising edge. Each vector therefore sees the effect of its own inputs only.

The sweep covers all four pending combinations with all eight mode combinations. It runs the space in both directions, so each input changes in both directions between consecutive vectors. The data bytes are changed on every vector so that a stale or wrongly selected byte is caught.

// File: rtl/kbd_obuf_pkg.sv
package kbd_obuf_pkg;

  // Decisions the control half hands to the datapath registers.
  typedef struct packed {
    logic anyPend;   // some channel holds a byte
    logic selAux;    // auxiliary is the sole pending channel
    logic kbdIrq;    // keyboard interrupt qualified
    logic auxIrq;    // auxiliary interrupt qualified
  } arbStrobe_t;

  localparam arbStrobe_t STROBE_IDLE = '{default: 1'b0};

endpackage

// File: rtl/kbd_obuf_ctrl.sv
module kbd_obuf_ctrl
  import kbd_obuf_pkg::*;
(
  input  logic       kbdPending,
  input  logic       auxPending,
  input  logic       modeKbdIrqEn,
  input  logic       modeAuxIrqEn,
  input  logic       modeKbdOff,
  output arbStrobe_t strobe
);

  logic auxOnly;
  logic kbdWins;

  // Keyboard has fixed priority: auxiliary is chosen only when alone.
  assign auxOnly = auxPending & ~kbdPending;
  assign kbdWins = kbdPending;

  always_comb begin
    strobe         = STROBE_IDLE;
    strobe.anyPend = kbdPending | auxPending;
    strobe.selAux  = auxOnly;
    strobe.auxIrq  = auxOnly & modeAuxIrqEn;
    strobe.kbdIrq  = kbdWins & modeKbdIrqEn & ~modeKbdOff;
  end

endmodule

// File: rtl/kbd_obuf_dpath.sv
module kbd_obuf_dpath
  import kbd_obuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  arbStrobe_t        strobe,
  input  logic              modeKbdOff,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] auxByte,
  output logic              obfQ,
  output logic              auxObfQ,
  output logic              irqKbdQ,
  output logic              irqAuxQ,
  output logic              selAuxQ,
  output logic [DATA_W-1:0] byteQ
);

  logic [DATA_W-1:0] byteMux;

  assign byteMux = strobe.selAux ? auxByte : kbdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      obfQ    <= 1'b0;
      auxObfQ <= 1'b0;
      irqKbdQ <= 1'b0;
      irqAuxQ <= 1'b0;
      selAuxQ <= 1'b0;
      byteQ   <= '0;
    end else begin
      obfQ    <= strobe.anyPend;
      auxObfQ <= strobe.selAux;
      irqKbdQ <= strobe.kbdIrq;
      irqAuxQ <= strobe.auxIrq;
      selAuxQ <= strobe.selAux;
      byteQ   <= byteMux;
    end
  end

  AST_AUX_FLAG_NEEDS_OBF: assert property (@(posedge clk) disable iff (!rstN) auxObfQ |-> obfQ); // R3
  AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN) !(irqKbdQ && irqAuxQ)); // R4
  AST_OBF_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN) strobe.anyPend |=> obfQ); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN) !strobe.anyPend |=> (!obfQ && !irqKbdQ && !irqAuxQ && !auxObfQ)); // R8
  AST_KBD_OFF_MASKS: assert property (@(posedge clk) disable iff (!rstN) modeKbdOff |=> !irqKbdQ); // R5
  AST_AUX_IRQ_HAS_FLAG: assert property (@(posedge clk) disable iff (!rstN) irqAuxQ |-> auxObfQ); // R4
  AST_SEL_MATCHES_FLAG: assert property (@(posedge clk) disable iff (!rstN) strobe.selAux |=> selAuxQ && auxObfQ); // R7

endmodule

// File: rtl/kbd_obuf_arbiter.sv
module kbd_obuf_arbiter
  import kbd_obuf_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              kbdPending,
  input  logic              auxPending,
  input  logic              modeKbdIrqEn,
  input  logic              modeAuxIrqEn,
  input  logic              modeKbdOff,
  input  logic [DATA_W-1:0] kbdByte,
  input  logic [DATA_W-1:0] auxByte,
  output logic              statusObf,
  output logic              statusAuxObf,
  output logic              portObf,
  output logic              portAuxObf,
  output logic              irqKbd,
  output logic              irqAux,
  output logic              readSelAux,
  output logic [DATA_W-1:0] readByte
);

  arbStrobe_t strobe;

  kbd_obuf_ctrl uCtrl (
    .kbdPending  (kbdPending),
    .auxPending  (auxPending),
    .modeKbdIrqEn(modeKbdIrqEn),
    .modeAuxIrqEn(modeAuxIrqEn),
    .modeKbdOff  (modeKbdOff),
    .strobe      (strobe)
  );

  kbd_obuf_dpath #(.DATA_W(DATA_W)) uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeKbdOff(modeKbdOff),
    .kbdByte   (kbdByte),
    .auxByte   (auxByte),
    .obfQ      (statusObf),
    .auxObfQ   (statusAuxObf),
    .irqKbdQ   (irqKbd),
    .irqAuxQ   (irqAux),
    .selAuxQ   (readSelAux),
    .byteQ     (readByte)
  );

  // Output port copies share the status registers (R6).
  assign portObf    = statusObf;
  assign portAuxObf = statusAuxObf;

endmodule

// File: tb/tb_kbd_obuf_arbiter.sv
module tb_kbd_obuf_arbiter;

  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic kbdPending = 1'b0, auxPending = 1'b0;
  logic modeKbdIrqEn = 1'b0, modeAuxIrqEn = 1'b0, modeKbdOff = 1'b0;
  logic [DATA_W-1:0] kbdByte = '0, auxByte = '0;
  logic statusObf, statusAuxObf, portObf, portAuxObf, irqKbd, irqAux, readSelAux;
  logic [DATA_W-1:0] readByte;

  int vectors = 0;
  int miscompares = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  kbd_obuf_arbiter #(.DATA_W(DATA_W)) dut (
    .clk(clk), .rstN(rstN),
    .kbdPending(kbdPending), .auxPending(auxPending),
    .modeKbdIrqEn(modeKbdIrqEn), .modeAuxIrqEn(modeAuxIrqEn), .modeKbdOff(modeKbdOff),
    .kbdByte(kbdByte), .auxByte(auxByte),
    .statusObf(statusObf), .statusAuxObf(statusAuxObf),
    .portObf(portObf), .portAuxObf(portAuxObf),
    .irqKbd(irqKbd), .irqAux(irqAux),
    .readSelAux(readSelAux), .readByte(readByte)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic applyAndCheck(input int code, input int salt);
    bit k, a, ie, ae, off, auxOnly;
    int kb, ab;
    k = code[0]; a = code[1]; ie = code[2]; ae = code[3]; off = code[4];
    kb = (salt * 37 + 11) % 256;
    ab = (salt * 91 + 200) % 256;
    @(negedge clk);
    kbdPending = k; auxPending = a;
    modeKbdIrqEn = ie; modeAuxIrqEn = ae; modeKbdOff = off;
    kbdByte = kb[DATA_W-1:0]; auxByte = ab[DATA_W-1:0];
    @(negedge clk);  // one rising edge later
    auxOnly = a && !k;
    chk("R2", "statusObf", statusObf, int'(k || a));
    chk("R3", "statusAuxObf", statusAuxObf, int'(auxOnly));
    chk("R4", "irqAux", irqAux, int'(auxOnly && ae));
    chk("R5", "irqKbd", irqKbd, int'(k && ie && !off));
    chk("R6", "portObf", portObf, int'(statusObf));
    chk("R6", "portAuxObf", portAuxObf, int'(statusAuxObf));
    chk("R7", "readSelAux", readSelAux, int'(auxOnly));
    chk("R7", "readByte", int'(readByte), auxOnly ? ab : kb);
    if (!k && !a)
      chk("R8", "idle lines", int'({statusObf, statusAuxObf, irqKbd, irqAux}), 0);
  endtask

  initial begin
    // R1: outputs under reset, with inputs active
    kbdPending = 1'b1; auxPending = 1'b1; modeKbdIrqEn = 1'b1; modeAuxIrqEn = 1'b1;
    kbdByte = 8'hA5; auxByte = 8'h5A;
    repeat (3) @(negedge clk);
    chk("R1", "flags in reset", int'({statusObf, statusAuxObf, portObf, portAuxObf}), 0);
    chk("R1", "irqs in reset", int'({irqKbd, irqAux, readSelAux}), 0);
    chk("R1", "readByte in reset", int'(readByte), 0);
    rstN = 1'b1;
    // R2..R8: exhaustive sweep, forward then backward
    for (int pass = 0; pass < 2; pass++) begin
      for (int i = 0; i < 32; i++) begin
        applyAndCheck(pass == 0 ? i : 31 - i, pass * 32 + i);
      end
    end
    // Alternating sole-source patterns
    for (int i = 0; i < 16; i++) begin
      applyAndCheck((i % 2 == 0) ? 5'b01110 : 5'b01101, 100 + i);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      vectors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule